// File: doc/BRIEF.md
# SD Four-Lane Read Block Receiver

This block takes in one read data block from an SD card over the four-line data bus, clocked by the card clock. After a start-read pulse it waits for the start condition, which is all four lines low in the same cycle. It then samples one nibble per clock and joins each pair of nibbles into a byte, putting the earlier nibble in the upper half. Each finished byte goes out through a one-cycle write strobe into a receive FIFO.

Each data line carries its own CRC16 trailer, and the block checks it against a running remainder kept for that line alone. A closing end bit, which must be high, follows the trailer. A busy flag spans the whole transfer. When busy drops, an error flag reports the outcome, and the flag holds until the next transfer is started. Every start clears all counters and the nibble phase, so blocks can be issued back to back, and the first block after reset, with no earlier activity, is received correctly.

Top module: `sdrx_top`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `fifoWe` and `crcErr` are 0 until a start pulse arrives.
- R2: A `startRd` pulse sampled while idle makes `busy` read 1 after that clock edge.
- R3: After a start, the block stays waiting and writes nothing until a cycle in which `dat` is 4'b0000. A nibble with only some lines low does not start the block.
- R4: Each byte is formed from two consecutive nibbles. The first nibble goes to bits 7:4 (`dat[3]` to bit 7) and the second goes to bits 3:0, so a byte sent as 0x12 is written as 0x12.
- R5: Each block produces exactly BLOCK_BYTES write pulses, one per byte, in arrival order. Each pulse is one cycle long.
- R6: Data line i carries bit i of every nibble. It is followed by 16 CRC bits, most significant first, computed with polynomial x^16+x^12+x^5+1 (0x1021) starting from zero over that line's payload bits. A mismatch on any line sets `crcErr`.
- R7: The cycle after the CRC bits carries the end bit. If any line is low in that cycle, `crcErr` is set.
- R8: `busy` falls on the edge that samples the end bit. `crcErr` takes its result on that same edge and holds it until the next start.
- R9: A `startRd` pulse while `busy` is 1 has no effect on the data, the byte count or the error result.
- R10: Counters and the nibble phase are cleared on every start, so repeated blocks each deliver the full and correct byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the data lines are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startRd | input | 1 | Pulse that arms reception of one block |
| dat | input | 4 | Data lines from the card |
| busy | output | 1 | High from the start pulse until the end bit is taken |
| fifoWe | output | 1 | One-cycle write strobe for the receive FIFO |
| fifoData | output | 8 | Byte to be written, valid with `fifoWe` |
| crcErr | output | 1 | CRC or end-bit failure of the last block, valid when `busy` falls |

## Verification
If the nibble phase were left over from an earlier transfer, every byte of the next block would come out shifted by half a byte, and the first write would already show it. A byte counter that is not cleared would move the fall of `busy` and change the number of writes, and that is visible at the end of the block. A wrong CRC bit order or a wrong tap would leave `crcErr` low on a corrupted line, or raise it on clean data, on the edge where `busy` drops. The sweep covers all 256 byte values and corrupts each line in turn, so each of these faults changes a port value within one block.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rxState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // new transfer armed: wipe per-block state
    logic takeNib;   // a payload nibble is on the lines
    logic lowHalf;   // that nibble is the second half of a byte
    logic checkCrc;  // a CRC bit is on the lines
    logic endBit;    // the end bit is on the lines
  } rxStrobe_t;

endpackage

// File: rtl/sdrx_ctrl.sv
module sdrx_ctrl
  import sdrx_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int LANES       = 4,
  parameter int CRC_BITS    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic [LANES-1:0] dat,
  output rxStrobe_t        stb,
  output logic             busy
);

  localparam int NIBBLES = 2 * BLOCK_BYTES;
  localparam int NIB_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
  localparam int CRC_CW  = (CRC_BITS > 1) ? $clog2(CRC_BITS) : 1;
  localparam logic [NIB_W-1:0]  NIB_LAST = NIB_W'(NIBBLES - 1);
  localparam logic [CRC_CW-1:0] CRC_LAST = CRC_CW'(CRC_BITS - 1);

  rxState_t          state, stateNxt;
  logic [NIB_W-1:0]  nibCnt;
  logic [CRC_CW-1:0] crcCnt;
  logic              startSeen;

  assign startSeen = (dat == '0);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (startRd)                stateNxt = ST_WAIT;
      ST_WAIT: if (startSeen)              stateNxt = ST_DATA;
      ST_DATA: if (nibCnt == NIB_LAST)     stateNxt = ST_CRC;
      ST_CRC:  if (crcCnt == CRC_LAST)     stateNxt = ST_END;
      ST_END:                              stateNxt = ST_IDLE;
      default:                             stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibCnt <= '0;
      crcCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && startRd) begin
        nibCnt <= '0;
        crcCnt <= '0;
      end else if (state == ST_DATA) begin
        nibCnt <= nibCnt + 1'b1;
      end else if (state == ST_CRC) begin
        crcCnt <= crcCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.clear    = (state == ST_IDLE) && startRd;
    stb.takeNib  = (state == ST_DATA);
    stb.lowHalf  = nibCnt[0];
    stb.checkCrc = (state == ST_CRC);
    stb.endBit   = (state == ST_END);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sdrx_dpath.sv
module sdrx_dpath
  import sdrx_pkg::*;
#(
  parameter int                LANES    = 4,
  parameter int                CRC_BITS = 16,
  parameter logic [CRC_BITS-1:0] POLY   = 16'h1021
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES-1:0]     dat,
  input  rxStrobe_t            stb,
  output logic                 fifoWe,
  output logic [2*LANES-1:0]   fifoData,
  output logic                 crcErr
);

  logic [LANES-1:0] hiNib;
  logic [LANES-1:0] laneBad;

  // Byte assembly: first nibble of a pair lands in the upper half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib    <= '0;
      fifoWe   <= 1'b0;
      fifoData <= '0;
    end else if (stb.clear) begin
      hiNib    <= '0;
      fifoWe   <= 1'b0;
    end else begin
      fifoWe <= stb.takeNib & stb.lowHalf;
      if (stb.takeNib && !stb.lowHalf) hiNib <= dat;
      if (stb.takeNib &&  stb.lowHalf) fifoData <= {hiNib, dat};
    end
  end

  // One serial CRC remainder per data line
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CRC_BITS-1:0] remQ;
    logic                badQ;
    logic                feedBack;

    assign feedBack   = remQ[CRC_BITS-1] ^ dat[g];
    assign laneBad[g] = badQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        remQ <= '0;
        badQ <= 1'b0;
      end else if (stb.clear) begin
        remQ <= '0;
        badQ <= 1'b0;
      end else if (stb.takeNib) begin
        remQ <= {remQ[CRC_BITS-2:0], 1'b0} ^ (feedBack ? POLY : '0);
      end else if (stb.checkCrc) begin
        if (dat[g] != remQ[CRC_BITS-1]) badQ <= 1'b1;
        remQ <= {remQ[CRC_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           crcErr <= 1'b0;
    else if (stb.clear)  crcErr <= 1'b0;
    else if (stb.endBit) crcErr <= (|laneBad) | ~(&dat);
  end

endmodule

// File: rtl/sdrx_top.sv
module sdrx_top
  import sdrx_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startRd,
  input  logic [3:0] dat,
  output logic       busy,
  output logic       fifoWe,
  output logic [7:0] fifoData,
  output logic       crcErr
);

  localparam int LANES    = 4;
  localparam int CRC_BITS = 16;

  rxStrobe_t stb;

  sdrx_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .LANES      (LANES),
    .CRC_BITS   (CRC_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startRd(startRd),
    .dat    (dat),
    .stb    (stb),
    .busy   (busy)
  );

  sdrx_dpath #(
    .LANES   (LANES),
    .CRC_BITS(CRC_BITS),
    .POLY    (16'h1021)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .dat     (dat),
    .stb     (stb),
    .fifoWe  (fifoWe),
    .fifoData(fifoData),
    .crcErr  (crcErr)
  );

endmodule

// File: rtl/sdrx_chk.sv
module sdrx_chk #(
  parameter int BLOCK_BYTES = 512
) (
  input logic clk,
  input logic rstN,
  input logic startRd,
  input logic busy,
  input logic fifoWe,
  input logic crcErr
);

  localparam int CW = $clog2(BLOCK_BYTES + 2) + 1;
  logic [CW-1:0] wrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrCnt <= '0;
    else if (startRd && !busy) wrCnt <= '0;
    else if (fifoWe)           wrCnt <= wrCnt + 1'b1;
  end

  // R2
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startRd && !busy) |=> busy);

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startRd));

  // R3
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWe |-> busy);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWe |=> !fifoWe);

  // R5
  block_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (wrCnt == CW'(BLOCK_BYTES)));

  // R8
  err_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(crcErr));

  // R1
  always_comb begin
    if (!rstN) begin
      reset_idle_chk: assert (!fifoWe && !crcErr);
    end
  end

endmodule

bind sdrx_top sdrx_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .startRd(startRd),
  .busy   (busy),
  .fifoWe (fifoWe),
  .crcErr (crcErr)
);

// File: tb/sim_sdrx_top.sv
`timescale 1ns/1ps
module sim_sdrx_top;

  localparam int BB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startRd = 1'b0;
  logic [3:0] dat = 4'hF;
  logic       busy, fifoWe, crcErr;
  logic [7:0] fifoData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] tx [BB];
  logic [7:0] rx [BB];
  int rxCnt = 0;

  always #2 clk = ~clk;

  sdrx_top #(.BLOCK_BYTES(BB)) u0 (
    .clk(clk), .rstN(rstN), .startRd(startRd), .dat(dat),
    .busy(busy), .fifoWe(fifoWe), .fifoData(fifoData), .crcErr(crcErr)
  );

  always @(negedge clk) begin
    if (rstN && fifoWe) begin
      if (rxCnt < BB) rx[rxCnt] = fifoData;
      rxCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference remainder for one line, from the polynomial definition
  function automatic logic [15:0] laneCrc(input int lane);
    logic [15:0] c = '0;
    for (int b = 0; b < BB; b++) begin
      for (int h = 0; h < 2; h++) begin
        logic bitIn;
        logic fb;
        bitIn = tx[b][(h == 0 ? 4 : 0) + lane];
        fb = c[15] ^ bitIn;
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic runBlock(input int flipLane, input bit badEnd,
                          input bit midStrobe, input bit partialLow);
    logic [15:0] c [4];
    bit expErr;
    for (int l = 0; l < 4; l++) c[l] = laneCrc(l);
    expErr = (flipLane >= 0) || badEnd;
    rxCnt = 0;
    @(negedge clk); startRd = 1'b1;
    @(negedge clk); startRd = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    dat = 4'hF;
    @(negedge clk);
    if (partialLow) begin
      dat = 4'b0101; @(negedge clk);
      dat = 4'b1000; @(negedge clk);
      dat = 4'b0001; @(negedge clk);
    end
    dat = 4'hF; @(negedge clk);
    check(rxCnt == 0 && busy, "R3", "no write before start bit", rxCnt, 0);
    dat = 4'h0;
    for (int b = 0; b < BB; b++) begin
      @(negedge clk);
      dat = tx[b][7:4];
      startRd = (midStrobe && b == BB / 2);
      @(negedge clk);
      startRd = 1'b0;
      dat = tx[b][3:0];
    end
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) dat[l] = c[l][k] ^ (l == flipLane && k == 7);
    end
    @(negedge clk);
    dat = badEnd ? 4'b1011 : 4'hF;
    check(busy == 1'b1, "R8", "busy before end bit", busy, 1);
    @(negedge clk);
    dat = 4'hF;
    check(busy == 1'b0, "R8", "busy after end bit", busy, 0);
    check(crcErr == expErr, expErr ? (badEnd ? "R7" : "R6") : "R6",
          "crc flag", crcErr, expErr);
    check(rxCnt == BB, midStrobe ? "R9" : "R5", "write count", rxCnt, BB);
    for (int b = 0; b < BB; b++)
      check(rx[b] === tx[b], "R4", "byte value", rx[b], tx[b]);
    repeat (2) @(negedge clk);
    check(crcErr == expErr, "R8", "flag held while idle", crcErr, expErr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && fifoWe == 0 && crcErr == 0, "R1", "outputs in reset",
          {busy, fifoWe, crcErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && fifoWe == 0 && crcErr == 0, "R1", "outputs after reset",
          {busy, fifoWe, crcErr}, 0);

    // R10: back-to-back blocks sweeping every byte value, first one right after reset
    for (int k = 0; k < 256 / BB; k++) begin
      for (int i = 0; i < BB; i++) tx[i] = 8'(k * BB + i);
      runBlock(-1, 1'b0, 1'b0, k == 1);
    end
    // R6: corrupt one CRC bit on each line in turn
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < BB; i++) tx[i] = 8'(i * 37 + 5 + l);
      runBlock(l, 1'b0, 1'b0, 1'b0);
    end
    // R10: clean block after an error clears the flag
    for (int i = 0; i < BB; i++) tx[i] = 8'h12;
    runBlock(-1, 1'b0, 1'b0, 1'b0);
    // R7: good CRC but a low end bit
    for (int i = 0; i < BB; i++) tx[i] = 8'(255 - i * 3);
    runBlock(-1, 1'b1, 1'b0, 1'b0);
    // R9: stray start pulse in the middle of the payload
    for (int i = 0; i < BB; i++) tx[i] = 8'(i * 11 + 1);
    runBlock(-1, 1'b0, 1'b1, 1'b0);
    // R10: payload of all zeros and all ones
    for (int i = 0; i < BB; i++) tx[i] = 8'h00;
    runBlock(-1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < BB; i++) tx[i] = 8'hFF;
    runBlock(-1, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule